// File: doc/BRIEF.md
# Mixed-Length Instruction Stream Aligner

This block sits between instruction fetch and decode. Fetch hands it one 32-bit beat at a time, holding two 16-bit halfwords. The lower halfword comes first in program order. The aligner looks at the leading halfword of each instruction to decide whether the instruction is 16 or 32 bits long. It joins a second halfword to the first when the instruction needs one, and it presents exactly one whole instruction per output handshake.

Short and long instructions may follow one another in any order with no mode change. A long instruction often begins in the upper half of one beat and ends in the lower half of the next, so the block keeps a leftover halfword from beat to beat. A flush input discards everything held when fetch is redirected. A companion select bit tells the aligner that the redirected stream starts at the upper halfword of the next beat.

The control is a fill-level state machine with five states. `ST_EMPTY` holds nothing. `ST_SKIP` holds nothing and will drop the lower halfword of the next beat. `ST_ONE`, `ST_TWO` and `ST_THREE` hold that many halfwords. The transitions are:
- **load**: a beat is accepted, which adds two halfwords, or one from `ST_SKIP`.
- **issue**: an instruction is handed out, which removes one or two halfwords.
- **load+issue**: both happen in the same cycle.
- **hold**: neither happens.
- **flush**: the block goes to `ST_EMPTY`, or to `ST_SKIP` when the select bit is set.

Top module: `instr_aligner`

## Requirements
- R1: A leading halfword whose bits [15:13] are not 3'b111 is issued alone. `out_is32` is 0, `out_short_br` is 0, and `out_instr` is {16'h0000, halfword}.
- R2: A leading halfword with bits [15:11] equal to 5'b11100 is issued alone as a short unconditional branch. `out_is32` is 0, `out_short_br` is 1, and `out_instr` is {16'h0000, halfword}.
- R3: A leading halfword with bits [15:13] equal to 3'b111 and bits [12:11] not 2'b00 starts a long instruction. The block issues it with `out_is32` = 1 and `out_instr` = {leading halfword, following halfword}.
- R4: Instructions are issued in program order for any mix of short and long encodings. Within a beat, bits [15:0] come before bits [31:16].
- R5: When a long instruction starts in bits [31:16] of a beat, it is completed with bits [15:0] of the next accepted beat.
- R6: While `out_valid` is 1 and `out_ready` is 0, and no flush occurs, `out_valid` stays 1 and `out_instr`, `out_is32` and `out_short_br` hold their values.
- R7: A flush forces `out_valid` to 0 in its own cycle. Every held halfword and every unissued instruction is dropped, a beat handshaken in that cycle is ignored, and `in_ready` is 1 in the following cycle.
- R8: A flush with `flush_odd` = 1 drops bits [15:0] of the first beat accepted afterwards. The stream restarts at bits [31:16] of that beat.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: `in_ready` is 0 exactly when two or more halfwords are held. In that case a complete instruction is always on offer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Drop all held state (redirect) |
| flush_odd | input | 1 | With flush: restart at the upper halfword of the next beat |
| in_valid | input | 1 | Fetch beat valid |
| in_ready | output | 1 | Aligner can take a beat |
| in_beat | input | 32 | Two halfwords; [15:0] first in program order |
| out_valid | output | 1 | Aligned instruction valid |
| out_ready | input | 1 | Decode takes the instruction |
| out_instr | output | 32 | Aligned instruction word (zero when not valid) |
| out_is32 | output | 1 | Instruction is 32 bits long |
| out_short_br | output | 1 | Instruction is the short unconditional branch |

## Verification
The hardest case to reach from the ports is a flush that lands while the only thing held is the first half of a long instruction, sitting in the upper half of a beat. Nothing is on offer at that moment, so the stale half can only show up later, if it gets paired with the next beat. The bench feeds a beat whose upper half starts a long instruction and waits until the short instruction in front of it has drained. It then flushes with the odd-start select set. The next beat carries another long-instruction prefix in its dropped lower half, so a leftover that was not discarded, or a lower half that was not skipped, yields a visibly wrong word. Back-pressure is held low while beats arrive, to fill the buffer and push `in_ready` low.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

    // Fill level of the halfword buffer; ST_SKIP is empty with the next
    // lower halfword to be dropped.
    typedef enum logic [2:0] {
        ST_EMPTY = 3'd0,
        ST_SKIP  = 3'd1,
        ST_ONE   = 3'd2,
        ST_TWO   = 3'd3,
        ST_THREE = 3'd4
    } fill_state_e;

    localparam int BEAT_HW = 2;             // halfwords per fetch beat
    localparam int SLOTS   = BEAT_HW + 1;   // leftover + one full beat

endpackage

// File: rtl/aligner_len_classify.sv
// Length classification from the five top bits of a leading halfword.
module aligner_len_classify (
    input  logic [4:0] code,
    output logic       is_long,
    output logic       is_short_br
);
    logic prefix_hit;

    always_comb begin
        prefix_hit  = (code[4:2] == 3'b111);
        is_long     = prefix_hit && (code[1:0] != 2'b00);
        is_short_br = prefix_hit && (code[1:0] == 2'b00);
    end
endmodule

// File: rtl/aligner_hw_buffer.sv
// Shift-down halfword store: pop from the head, append behind the survivors.
module aligner_hw_buffer #(
    parameter int HALF_W = 16,
    parameter int SLOTS  = 3,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [1:0]          pop,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_two,
    input  logic [2*HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0]   head,
    output logic [HALF_W-1:0]   second
);
    logic [SLOTS-1:0][HALF_W-1:0] slot_q;
    logic [SLOTS-1:0][HALF_W-1:0] slot_d;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [HALF_W-1:0] nv;
        always_comb begin
            nv = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (s == i + int'(pop)) nv = slot_q[s];
            end
            if (wr_en && int'(wr_idx) == i)
                nv = wr_two ? wr_data[HALF_W-1:0] : wr_data[2*HALF_W-1:HALF_W];
            if (wr_en && wr_two && int'(wr_idx) + 1 == i)
                nv = wr_data[2*HALF_W-1:HALF_W];
        end
        assign slot_d[i] = nv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot_q <= '0;
        else if (clear) slot_q <= '0;
        else            slot_q <= slot_d;
    end

    assign head   = slot_q[0];
    assign second = slot_q[1];
endmodule

// File: rtl/aligner_fill_fsm.sv
// Fill-level controller: handshakes, pop/push amounts, flush handling.
module aligner_fill_fsm
    import aligner_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             flush_odd,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             head_is_long,
    output logic             in_ready,
    output logic             out_valid,
    output logic [1:0]       pop,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_two,
    output logic             clear
);
    fill_state_e state_q, state_d;
    logic [2:0]  cnt;
    logic [2:0]  push;
    logic [2:0]  fill_next;
    logic        fire;
    logic        accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Occupancy implied by the state
    always_comb begin
        unique case (state_q)
            ST_EMPTY, ST_SKIP: cnt = 3'd0;
            ST_ONE:            cnt = 3'd1;
            ST_TWO:            cnt = 3'd2;
            ST_THREE:          cnt = 3'd3;
            default:           cnt = 3'd0;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        out_valid = !flush && ((cnt >= 3'd2) || (cnt == 3'd1 && !head_is_long));
        fire      = out_valid && out_ready;
        pop       = fire ? (head_is_long ? 2'd2 : 2'd1) : 2'd0;
        in_ready  = (state_q == ST_EMPTY) || (state_q == ST_SKIP) || (state_q == ST_ONE);
        accept    = in_valid && in_ready && !flush;
        wr_en     = accept;
        wr_two    = (state_q != ST_SKIP);
        push      = accept ? (wr_two ? 3'd2 : 3'd1) : 3'd0;
        wr_idx    = IDX_W'(cnt - {1'b0, pop});
        clear     = flush;
    end

    // Next state: flush, else load / issue / load+issue / hold by new level
    always_comb begin
        fill_next = cnt - {1'b0, pop} + push;
        state_d   = state_q;
        if (flush) begin
            state_d = flush_odd ? ST_SKIP : ST_EMPTY;
        end else begin
            unique case (fill_next)
                3'd0:    state_d = (state_q == ST_SKIP) ? ST_SKIP : ST_EMPTY;
                3'd1:    state_d = ST_ONE;
                3'd2:    state_d = ST_TWO;
                3'd3:    state_d = ST_THREE;
                default: state_d = ST_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/instr_aligner.sv
module instr_aligner
    import aligner_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                flush_odd,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2*HALF_W-1:0] in_beat,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*HALF_W-1:0] out_instr,
    output logic                out_is32,
    output logic                out_short_br
);
    localparam int IDX_W = $clog2(SLOTS + 1);

    logic [HALF_W-1:0] head, second;
    logic              head_long, head_sbr;
    logic [1:0]        pop;
    logic              wr_en, wr_two, clear;
    logic [IDX_W-1:0]  wr_idx;

    aligner_len_classify u_cls (
        .code        (head[HALF_W-1 -: 5]),
        .is_long     (head_long),
        .is_short_br (head_sbr)
    );

    aligner_fill_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .flush_odd    (flush_odd),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .head_is_long (head_long),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .pop          (pop),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_two       (wr_two),
        .clear        (clear)
    );

    aligner_hw_buffer #(.HALF_W(HALF_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .pop     (pop),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_two  (wr_two),
        .wr_data (in_beat),
        .head    (head),
        .second  (second)
    );

    always_comb begin
        out_is32     = out_valid && head_long;
        out_short_br = out_valid && head_sbr;
        if (!out_valid)     out_instr = '0;
        else if (head_long) out_instr = {head, second};
        else                out_instr = {{HALF_W{1'b0}}, head};
    end
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [2*HALF_W-1:0] out_instr,
    input logic                out_is32,
    input logic                out_short_br
);
    assert_short_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is32) |-> (out_instr[2*HALF_W-1:HALF_W] == '0));

    assert_branch_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_short_br |-> (!out_is32 && out_instr[HALF_W-1 -: 5] == 5'b11100));

    assert_long_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_is32 |-> (out_instr[2*HALF_W-1 -: 3] == 3'b111 &&
                      out_instr[2*HALF_W-4 -: 2] != 2'b00));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && $past(out_valid && !out_ready && !flush)) |->
            (out_valid && $stable(out_instr) && $stable(out_is32) && $stable(out_short_br)));

    assert_flush_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    assert_flush_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> in_ready);

    assert_stall_has_work_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid || flush));
endmodule

bind instr_aligner aligner_checker #(.HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_instr    (out_instr),
    .out_is32     (out_is32),
    .out_short_br (out_short_br)
);

// File: tb/sim_instr_aligner.sv
`timescale 1ns/1ps
module sim_instr_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, flush_odd = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_beat = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_instr;
    logic        out_is32, out_short_br;

    always #2 clk = ~clk;

    instr_aligner u0 (.*);

    typedef struct {
        logic [31:0] instr;
        bit          is32;
        bit          sbr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   rdy_rand = 1'b0;
    bit   rdy_hold = 1'b1;
    bit   done = 1'b0;

    task automatic check(bit ok, string req, logic [33:0] act, logic [33:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic bit is_long(logic [15:0] h);
        return h[15:13] == 3'b111 && h[12:11] != 2'b00;
    endfunction

    // Expected items from a halfword list (complete instructions only)
    task automatic model(logic [15:0] hws[$]);
        int i = 0;
        while (i < hws.size()) begin
            exp_t e;
            if (is_long(hws[i])) begin
                if (i + 1 >= hws.size()) break;
                e.instr = {hws[i], hws[i+1]}; e.is32 = 1; e.sbr = 0; e.tag = "R3/R4/R5";
                i += 2;
            end else begin
                e.instr = {16'h0, hws[i]}; e.is32 = 0;
                e.sbr = (hws[i][15:11] == 5'b11100);
                e.tag = e.sbr ? "R2/R4" : "R1/R4";
                i += 1;
            end
            exp_q.push_back(e);
        end
    endtask

    task automatic drive_beat(logic [31:0] b);
        bit ok;
        in_valid = 1'b1; in_beat = b;
        do begin
            @(negedge clk); ok = in_ready;
            @(posedge clk); #1;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    // Model the stream then send it as beats; odd start puts a junk
    // long-prefix halfword in the lower half of the first beat.
    task automatic send_stream(logic [15:0] hws[$], bit odd);
        logic [15:0] p[$];
        p = hws;
        if ((p.size() + (odd ? 1 : 0)) % 2 != 0) p.push_back(16'h0123);
        model(p);
        if (odd) begin
            drive_beat({p[0], 16'hE9AB});
            p.pop_front();
        end
        while (p.size() != 0) begin
            logic [15:0] lo, hi;
            lo = p.pop_front(); hi = p.pop_front();
            drive_beat({hi, lo});
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    function automatic logic [15:0] h16();
        return {3'($urandom_range(0, 6)), 13'($urandom)};
    endfunction
    function automatic logic [15:0] hbr();
        return {5'b11100, 11'($urandom)};
    endfunction
    function automatic logic [15:0] hlong();
        return {3'b111, 2'($urandom_range(1, 3)), 11'($urandom)};
    endfunction

    // out_ready generator
    initial forever begin
        @(posedge clk); #0.5;
        out_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : rdy_hold;
    end

    // Monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected output", {out_is32, out_short_br, out_instr}, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_instr == e.instr && out_is32 == e.is32 && out_short_br == e.sbr,
                      e.tag, {out_is32, out_short_br, out_instr}, {e.is32, e.sbr, e.instr});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] s[$];
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", {33'b0, out_valid}, '0);
        check(in_ready == 1'b1, "R9 in_ready after reset", {33'b0, in_ready}, 34'd1);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: short only
        s = {h16(), h16(), h16(), h16(), h16(), h16()};
        send_stream(s, 0); drain();

        // R2, R3: aligned mix
        s = {hbr(), h16(), hlong(), 16'hABCD, hlong(), 16'h1234, hbr(), h16()};
        send_stream(s, 0); drain();

        // R5: long straddling beats
        s = {h16(), hlong(), 16'h5A5A, h16(), hlong(), 16'hC3C3, hlong(), 16'h0F0F};
        send_stream(s, 0); drain();

        // R4/R6: random mix with random back-pressure
        rdy_rand = 1'b1;
        for (int n = 0; n < 400; n++) begin
            int k = $urandom_range(0, 2);
            if (k == 0) s.push_back(h16());
            else if (k == 1) s.push_back(hbr());
            else begin s.push_back(hlong()); s.push_back(16'($urandom)); end
        end
        s.delete();
        for (int n = 0; n < 300; n++) begin
            int k = $urandom_range(0, 2);
            if (k == 0) s.push_back(h16());
            else if (k == 1) s.push_back(hbr());
            else begin s.push_back(hlong()); s.push_back(16'($urandom)); end
        end
        send_stream(s, 0); drain();
        rdy_rand = 1'b0; rdy_hold = 1'b0;
        repeat (2) @(posedge clk); #1;

        // R10 + R6: stall with two halfwords held
        s = {16'h0111, 16'h0222};
        model(s);
        drive_beat({16'h0222, 16'h0111});
        @(negedge clk);
        check(in_ready == 1'b0, "R10 in_ready low with two held", {33'b0, in_ready}, '0);
        held = out_instr;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_valid && out_instr == held, "R6 output held under stall",
                  {1'b0, out_valid, out_instr}, {2'b01, held});
        end
        rdy_hold = 1'b1;
        drain();

        // R7: flush with pending output
        rdy_hold = 1'b0;
        repeat (2) @(posedge clk); #1;
        drive_beat({16'h0444, 16'h0333});
        flush = 1'b1; exp_q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid low during flush", {33'b0, out_valid}, '0);
        @(posedge clk); #1;
        flush = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 pending dropped", {33'b0, out_valid}, '0);
        check(in_ready == 1'b1, "R7 in_ready after flush", {33'b0, in_ready}, 34'd1);
        rdy_hold = 1'b1;
        @(posedge clk); #1;

        // R7/R8: leftover long prefix, then flush to odd start
        exp_q.push_back('{32'h0000_0555, 1'b0, 1'b0, "R1"});
        drive_beat({16'hF0F0, 16'h0555});
        drain();
        @(negedge clk);
        check(out_valid == 1'b0, "R5 lone long prefix not issued", {33'b0, out_valid}, '0);
        @(posedge clk); #1;
        flush = 1'b1; flush_odd = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0; flush_odd = 1'b0;
        s = {h16(), hlong(), 16'h7777, hbr()};
        foreach (s[j]) if (j == 0) s[j] = 16'h0666;
        send_stream(s, 1); drain();
        check(exp_q.size() == 0, "R8 odd-start stream complete", 34'(exp_q.size()), '0);

        // R8 plain flush afterwards restarts at lower half
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        s = {hlong(), 16'h2468, h16(), h16()};
        send_stream(s, 0); drain();

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R4 nothing left over", {33'b0, out_valid}, '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule